// File: doc/BRIEF.md
# Reset Boot Address Selector

This block decides where a small 8-bit processor begins fetching after a reset. When reset is released it takes one snapshot of three board strap pins and three nonvolatile settings: a jump bit, a status byte and a vector byte. From that snapshot it works out a start address in two steps.

The first step picks the entry point. It is the application origin at 0000h, the status-check entry at FC03h, or the default loader at FC00h. The loader is chosen when the straps force it. The second step performs the status-byte check that would otherwise run as code at FC03h. This gives the address the processor finally lands on.

Both addresses are presented on their own ports. A one-cycle strobe marks the moment the final address becomes usable. A flag shows whether the pins, not the stored settings, forced loader entry. The CPU core, the loader program and flash programming live elsewhere.

Top module: `boot_vector_select`

## Requirements
- R1: While `rst` is high, and on the first clock after it rises, `stage1_addr` and `start_addr` read 0000h and `start_valid` and `forced_loader` read 0.
- R2: Inputs are captured only at the first rising clock edge with `rst` low after a reset. Any later change of straps or settings leaves every output unchanged until the next reset.
- R3: The straps force the loader when `strap_store_n` is 0, `strap_ext_access` is 1 and `strap_latch_en` is 1. Both `stage1_addr` and `start_addr` then read FC00h, whatever the jump bit, status byte and vector are.
- R4: Without the forcing strap pattern, a jump bit of 1 gives `stage1_addr` = 0000h and `start_addr` = 0000h.
- R5: Without the forcing pattern, a jump bit of 0 gives `stage1_addr` = FC03h. If the status byte is then 00h, `start_addr` = 0000h.
- R6: Without the forcing pattern, with a jump bit of 0 and a nonzero status byte, `start_addr` has the vector byte in bits 15:8 and 00h in bits 7:0. A vector of FCh gives FC00h.
- R7: `stage1_addr` takes its value one clock after the capture edge. `start_addr`, `forced_loader` and a single-cycle `start_valid` pulse follow one clock after that. All outputs then hold until reset.
- R8: `forced_loader` is 1 only when the strap pattern of R3 caused the selection. Otherwise it is 0.
- R9: `start_addr` never equals the service entry FFF0h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_store_n | input | 1 | Program-store enable strap, active low |
| strap_ext_access | input | 1 | External-access strap |
| strap_latch_en | input | 1 | Address-latch enable strap (board pull-up when unconnected) |
| cfg_jump_app | input | 1 | Nonvolatile jump bit: 1 selects direct application start |
| cfg_status | input | 8 | Nonvolatile boot status byte |
| cfg_vector | input | 8 | Nonvolatile boot vector high byte |
| stage1_addr | output | 16 | First-stage entry address |
| start_addr | output | 16 | Resolved final start address |
| start_valid | output | 1 | One-cycle strobe when start_addr is resolved |
| forced_loader | output | 1 | Loader entry was forced by the straps |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that straps and settings are stable at the capture edge. After the capture edge the inputs may do anything, so the stimulus deliberately scrambles them to random values. Every stimulus pattern is applied from a fresh reset with inputs settled before release. The patterns sweep all eight strap states, both jump-bit values, a zero and a nonzero status byte, and four vector bytes. The reference model predicts each output on every clock from the values present at the capture edge.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST1_APP    = 2'd0,
    ST1_CHECK  = 2'd1,
    ST1_FORCED = 2'd2
  } stage1_e;

  typedef struct packed {
    logic              forced;
    logic              jump_app;
    logic [BYTE_W-1:0] status;
    logic [BYTE_W-1:0] vector;
  } boot_cfg_t;
endpackage

// File: rtl/boot_strap_sampler.sv
module boot_strap_sampler
  import boot_sel_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_store_n,
  input  logic              strap_ext_access,
  input  logic              strap_latch_en,
  input  logic              cfg_jump_app,
  input  logic [BYTE_W-1:0] cfg_status,
  input  logic [BYTE_W-1:0] cfg_vector,
  output boot_cfg_t         cfg_q,
  output logic              cfg_go
);
  logic rst_d;
  logic force_now;

  assign force_now = ~strap_store_n & strap_ext_access & strap_latch_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_d  <= 1'b1;
      cfg_go <= 1'b0;
      cfg_q  <= '0;
    end else begin
      rst_d  <= 1'b0;
      cfg_go <= rst_d;
      if (rst_d) begin
        cfg_q.forced   <= force_now;
        cfg_q.jump_app <= cfg_jump_app;
        cfg_q.status   <= cfg_status;
        cfg_q.vector   <= cfg_vector;
      end
    end
  end
endmodule

// File: rtl/boot_stage_one.sv
module boot_stage_one
  import boot_sel_pkg::*;
#(
  parameter logic [BYTE_W-1:0] LOADER_PAGE = 8'hFC,
  parameter logic [BYTE_W-1:0] CHECK_LOW   = 8'h03,
  parameter logic [ADDR_W-1:0] APP_START   = 16'h0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_go,
  input  logic              forced,
  input  logic              jump_app,
  output stage1_e           s1_kind,
  output logic [ADDR_W-1:0] s1_addr,
  output logic              s1_go
);
  localparam logic [ADDR_W-1:0] LOADER_ADDR = {LOADER_PAGE, {BYTE_W{1'b0}}};
  localparam logic [ADDR_W-1:0] CHECK_ADDR  = {LOADER_PAGE, CHECK_LOW};

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_kind <= ST1_APP;
      s1_addr <= '0;
      s1_go   <= 1'b0;
    end else begin
      s1_go <= cfg_go;
      if (cfg_go) begin
        if (forced) begin
          s1_kind <= ST1_FORCED;
          s1_addr <= LOADER_ADDR;
        end else if (jump_app) begin
          s1_kind <= ST1_APP;
          s1_addr <= APP_START;
        end else begin
          s1_kind <= ST1_CHECK;
          s1_addr <= CHECK_ADDR;
        end
      end
    end
  end
endmodule

// File: rtl/boot_stage_two.sv
module boot_stage_two
  import boot_sel_pkg::*;
#(
  parameter logic [BYTE_W-1:0] LOADER_PAGE = 8'hFC,
  parameter logic [ADDR_W-1:0] APP_START   = 16'h0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s1_go,
  input  stage1_e           s1_kind,
  input  logic [BYTE_W-1:0] status,
  input  logic [BYTE_W-1:0] vector,
  output logic [ADDR_W-1:0] final_addr,
  output logic              final_go,
  output logic              forced_flag
);
  localparam logic [BYTE_W-1:0] ZERO_LOW = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      final_addr  <= '0;
      final_go    <= 1'b0;
      forced_flag <= 1'b0;
    end else begin
      final_go <= s1_go;
      if (s1_go) begin
        forced_flag <= (s1_kind == ST1_FORCED);
        unique case (s1_kind)
          ST1_FORCED: final_addr <= {LOADER_PAGE, ZERO_LOW};
          ST1_CHECK:  final_addr <= (status == '0) ? APP_START : {vector, ZERO_LOW};
          default:    final_addr <= APP_START;
        endcase
      end
    end
  end
endmodule

// File: rtl/boot_vector_select.sv
module boot_vector_select
  import boot_sel_pkg::*;
#(
  parameter logic [BYTE_W-1:0] LOADER_PAGE = 8'hFC,
  parameter logic [BYTE_W-1:0] CHECK_LOW   = 8'h03,
  parameter logic [ADDR_W-1:0] APP_START   = 16'h0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_store_n,
  input  logic              strap_ext_access,
  input  logic              strap_latch_en,
  input  logic              cfg_jump_app,
  input  logic [BYTE_W-1:0] cfg_status,
  input  logic [BYTE_W-1:0] cfg_vector,
  output logic [ADDR_W-1:0] stage1_addr,
  output logic [ADDR_W-1:0] start_addr,
  output logic              start_valid,
  output logic              forced_loader
);
  boot_cfg_t cfg_q;
  logic      cfg_go;
  stage1_e   s1_kind;
  logic      s1_go;

  boot_strap_sampler u_sample (
    .clk              (clk),
    .rst              (rst),
    .strap_store_n    (strap_store_n),
    .strap_ext_access (strap_ext_access),
    .strap_latch_en   (strap_latch_en),
    .cfg_jump_app     (cfg_jump_app),
    .cfg_status       (cfg_status),
    .cfg_vector       (cfg_vector),
    .cfg_q            (cfg_q),
    .cfg_go           (cfg_go)
  );

  boot_stage_one #(
    .LOADER_PAGE (LOADER_PAGE),
    .CHECK_LOW   (CHECK_LOW),
    .APP_START   (APP_START)
  ) u_one (
    .clk      (clk),
    .rst      (rst),
    .cfg_go   (cfg_go),
    .forced   (cfg_q.forced),
    .jump_app (cfg_q.jump_app),
    .s1_kind  (s1_kind),
    .s1_addr  (stage1_addr),
    .s1_go    (s1_go)
  );

  boot_stage_two #(
    .LOADER_PAGE (LOADER_PAGE),
    .APP_START   (APP_START)
  ) u_two (
    .clk         (clk),
    .rst         (rst),
    .s1_go       (s1_go),
    .s1_kind     (s1_kind),
    .status      (cfg_q.status),
    .vector      (cfg_q.vector),
    .final_addr  (start_addr),
    .final_go    (start_valid),
    .forced_flag (forced_loader)
  );
endmodule

// File: rtl/boot_vector_select_chk.sv
module boot_vector_select_chk #(
  parameter logic [7:0] LOADER_PAGE = 8'hFC,
  parameter logic [7:0] CHECK_LOW   = 8'h03
) (
  input logic        clk,
  input logic        rst,
  input logic [15:0] stage1_addr,
  input logic [15:0] start_addr,
  input logic        start_valid,
  input logic        forced_loader,
  input logic        cfg_go
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!start_valid && !forced_loader && start_addr == 16'h0000 && stage1_addr == 16'h0000));

  assert_hold_after_valid_R2: assert property (@(posedge clk) disable iff (rst)
    $past(start_valid) |-> ($stable(start_addr) && $stable(stage1_addr) && $stable(forced_loader) && !start_valid));

  assert_forced_target_R3: assert property (@(posedge clk) disable iff (rst)
    forced_loader |-> (start_addr == {LOADER_PAGE, 8'h00} && stage1_addr == {LOADER_PAGE, 8'h00}));

  assert_app_entry_R4: assert property (@(posedge clk) disable iff (rst)
    (start_valid && stage1_addr == 16'h0000) |-> start_addr == 16'h0000);

  assert_vector_low_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (start_valid && stage1_addr == {LOADER_PAGE, CHECK_LOW}) |-> start_addr[7:0] == 8'h00);

  assert_valid_timing_R7: assert property (@(posedge clk) disable iff (rst)
    cfg_go |-> ##2 start_valid);

  assert_valid_single_R7: assert property (@(posedge clk) disable iff (rst)
    start_valid |=> !start_valid);

  assert_flag_with_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(forced_loader) |-> start_valid);

  assert_no_service_entry_R9: assert property (@(posedge clk) disable iff (rst)
    start_valid |-> start_addr != 16'hFFF0);
endmodule

bind boot_vector_select boot_vector_select_chk #(
  .LOADER_PAGE (LOADER_PAGE),
  .CHECK_LOW   (CHECK_LOW)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .stage1_addr   (stage1_addr),
  .start_addr    (start_addr),
  .start_valid   (start_valid),
  .forced_loader (forced_loader),
  .cfg_go        (cfg_go)
);

// File: tb/boot_vector_select_test.sv
module boot_vector_select_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strap_store_n = 1'b1;
  logic        strap_ext_access = 1'b0;
  logic        strap_latch_en = 1'b1;
  logic        cfg_jump_app = 1'b0;
  logic [7:0]  cfg_status = 8'h00;
  logic [7:0]  cfg_vector = 8'hFC;
  logic [15:0] stage1_addr;
  logic [15:0] start_addr;
  logic        start_valid;
  logic        forced_loader;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int since_rel = 0;
  bit seen_edge = 1'b0;
  bit done = 1'b0;
  bit          m_force;
  logic [15:0] m_s1;
  logic [15:0] m_final;

  always #5 clk = ~clk;

  boot_vector_select uut (
    .clk              (clk),
    .rst              (rst),
    .strap_store_n    (strap_store_n),
    .strap_ext_access (strap_ext_access),
    .strap_latch_en   (strap_latch_en),
    .cfg_jump_app     (cfg_jump_app),
    .cfg_status       (cfg_status),
    .cfg_vector       (cfg_vector),
    .stage1_addr      (stage1_addr),
    .start_addr       (start_addr),
    .start_valid      (start_valid),
    .forced_loader    (forced_loader)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Reference model: snapshot at the first low-reset edge, then count edges.
  always @(posedge clk) begin
    cycles++;
    seen_edge <= 1'b1;
    if (rst) begin
      since_rel <= 0;
    end else begin
      if (since_rel == 0) begin
        m_force = !strap_store_n && strap_ext_access && strap_latch_en;
        if (m_force) begin
          m_s1 = 16'hFC00; m_final = 16'hFC00;
        end else if (cfg_jump_app) begin
          m_s1 = 16'h0000; m_final = 16'h0000;
        end else begin
          m_s1 = 16'hFC03;
          m_final = (cfg_status == 8'h00) ? 16'h0000 : {cfg_vector, 8'h00};
        end
      end
      if (since_rel < 50) since_rel <= since_rel + 1;
    end
  end

  always @(negedge clk) begin
    if (seen_edge && !done) begin
      if (since_rel == 0) begin
        check(stage1_addr == 16'h0000, "R1 stage1", stage1_addr, 16'h0000);
        check(start_addr == 16'h0000, "R1 start", start_addr, 16'h0000);
        check(!start_valid && !forced_loader, "R1 flags", {14'd0, start_valid, forced_loader}, 16'h0000);
      end else begin
        check(stage1_addr == ((since_rel >= 2) ? m_s1 : 16'h0000),
              (since_rel > 3) ? "R2 stage1 hold" : (m_force ? "R3 stage1" : (m_s1 == 16'h0000 ? "R4 stage1" : "R5 stage1")),
              stage1_addr, (since_rel >= 2) ? m_s1 : 16'h0000);
        check(start_addr == ((since_rel >= 3) ? m_final : 16'h0000),
              (since_rel > 3) ? "R2 start hold" : (m_force ? "R3 start" : (m_s1 == 16'h0000 ? "R4 start" : (m_final == 16'h0000 ? "R5 start" : "R6 start"))),
              start_addr, (since_rel >= 3) ? m_final : 16'h0000);
        check(start_valid == (since_rel == 3), "R7 strobe", {15'd0, start_valid}, {15'd0, since_rel == 3});
        check(forced_loader == (m_force && since_rel >= 3), "R8 flag", {15'd0, forced_loader}, {15'd0, m_force && since_rel >= 3});
        if (since_rel == 3) check(start_addr != 16'hFFF0, "R9 service entry", start_addr, 16'h0000);
      end
    end
  end

  initial begin
    logic [7:0] vecs [4];
    vecs[0] = 8'hFC; vecs[1] = 8'h00; vecs[2] = 8'h7A; vecs[3] = 8'hFF;
    for (int s = 0; s < 8; s++) begin
      for (int j = 0; j < 2; j++) begin
        for (int z = 0; z < 2; z++) begin
          for (int v = 0; v < 4; v++) begin
            @(negedge clk);
            rst = 1'b1;
            strap_store_n    = s[0];
            strap_ext_access = s[1];
            strap_latch_en   = s[2];
            cfg_jump_app     = j[0];
            cfg_status       = (z == 0) ? 8'h00 : (8'h01 << v);
            cfg_vector       = vecs[v];
            repeat (2) @(negedge clk);
            rst = 1'b0;
            @(negedge clk);
            // after the capture edge: scramble everything (R2)
            for (int k = 0; k < 6; k++) begin
              strap_store_n    = $urandom_range(0, 1);
              strap_ext_access = $urandom_range(0, 1);
              strap_latch_en   = $urandom_range(0, 1);
              cfg_jump_app     = $urandom_range(0, 1);
              cfg_status       = 8'($urandom_range(0, 255));
              cfg_vector       = 8'($urandom_range(0, 255));
              @(negedge clk);
            end
          end
        end
      end
    end
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    done = 1'b1;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule